// File: doc/BRIEF.md
# Flash Region CRC Sequencer

This block computes a CRC-32 over a region of flash contents. It fetches the data one burst at a time through a read-burst request port. Each returned beat is one 128-bit flash word. The block folds every word into a running 32-bit checksum. When the last burst has been absorbed, it raises a completion flag, and the checksum output then holds the result.

The region can be described in two ways:

- **Address-range mode.** The region is a start address and an end address. Both are bank-relative byte addresses. The end address names the flash word that opens the final burst.
- **Sector-list mode.** The region is a bitmap of sectors. The list is built one sector at a time with an add strobe, and it can be emptied with a clear strobe. A separate all-sectors strobe arms a pending flag that fills the whole list at launch.

A start strobe arms a pending flag, and the next idle cycle consumes it to launch the run. Dropping the enable clears the result, the list and both pending flags, and it aborts any run in progress.

Top module: `fcrc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req`, `start_pend` and `all_pend` are 0, and `crc_out` and `sect_list` are all zeros.
- R2: In range mode (`by_sect`=0), a burst of B bytes is requested at the start address rounded down to a multiple of B. Successive requests step by B. The run ends after the burst whose address is at or above the end address rounded down to a multiple of B. If the rounded end lies below the rounded start, exactly one burst is issued. Every requested address has bits [5:0] equal to zero, and `rd_req` stays high until `rd_ack`.
- R3: `burst_sel` values 0, 1, 2 and 3 give bursts of 4, 16, 64 and 256 words (B = 64, 256, 1024 and 4096 bytes). `rd_len` carries the word count, and the burst ends after that many `rd_vld` beats.
- R4: The checksum starts at 0xFFFFFFFF at launch and uses polynomial 0x04C11DB7. It is processed MSB-first with no reflection and no final XOR. Each 128-bit word is absorbed as four 32-bit lanes, bits [31:0] first and bits [127:96] last.
- R5: A one-cycle `add_sect` pulse sets bit `sect_num` of `sect_list`. A `clean_list` pulse clears the whole list, and it wins when both pulses arrive in the same cycle.
- R6: In sector mode, the sectors present in the list at launch are visited in ascending order. Sector s covers bytes s*8192 to s*8192+8191 and is read as consecutive bursts of B bytes.
- R7: A sector-mode launch with an empty list issues no request and completes with `crc_out` = 0xFFFFFFFF.
- R8: An `all_sect_req` pulse sets `all_pend`. At launch, `sect_list` becomes all ones and `all_pend` returns to 0.
- R9: A `start_req` pulse while idle sets `start_pend` on the next edge. On the following edge `start_pend` clears and `busy` rises.
- R10: `done` rises in the cycle `busy` falls after a run, holds the final checksum, and clears at the next launch.
- R11: A `clean_crc` pulse while idle sets `crc_out` to 0 and clears `done`.
- R12: While `crc_en` is 0, all of the following hold one edge later: `busy` is 0, `crc_out` is 0, `sect_list` is 0, and both pending flags are 0. Strobes applied while `crc_en` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_en | input | 1 | Block enable; low clears the result, the list and the pending flags, and aborts a run |
| by_sect | input | 1 | 1 selects sector-list mode, 0 selects range mode |
| burst_sel | input | 2 | Burst size code (4/16/64/256 words) |
| range_start | input | 17 | Range start byte address, bits [5:0] ignored |
| range_end | input | 17 | Byte address of the word that opens the last burst, bits [5:0] ignored |
| sect_num | input | 2 | Sector index used by `add_sect` |
| add_sect | input | 1 | Pulse: add `sect_num` to the list |
| clean_list | input | 1 | Pulse: empty the list |
| all_sect_req | input | 1 | Pulse: arm filling of the whole list at launch |
| start_req | input | 1 | Pulse: request a run |
| clean_crc | input | 1 | Pulse: clear the result while idle |
| rd_req | output | 1 | Burst request valid |
| rd_addr | output | 17 | Burst start byte address |
| rd_len | output | 9 | Burst length in flash words |
| rd_ack | input | 1 | Burst request accepted |
| rd_vld | input | 1 | Data beat valid |
| rd_data | input | 128 | Flash word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion flag |
| crc_out | output | 32 | Checksum result |
| sect_list | output | 4 | Sector bitmap |
| start_pend | output | 1 | Start armed, not yet consumed |
| all_pend | output | 1 | All-sectors fill armed |

## Verification
Range runs use an unaligned start and end with 4-word bursts, an unaligned start with 16-word bursts, and a reversed pair with 64-word bursts. Together these separate rounding-down of both bounds, stepping by the burst size, and the single-burst case. Sector runs use a sparse two-sector list with 256-word bursts and a single sector with 4-word bursts. These expose ordering, sector base arithmetic and the sector-boundary wrap.

An empty list, an all-sectors fill and an abort through the enable cover the degenerate paths. The flash words are derived from their addresses, so a wrong address, an out-of-order lane or a skipped beat each change the checksum.

// File: rtl/fcrc_pkg.sv
`timescale 1ns/1ps
// Shared constants, the walker state type and the checksum step functions.
// Assumes a 128-bit flash word split into 32-bit lanes.
package fcrc_pkg;
    localparam int WORD_W = 128;
    localparam int CRC_W  = 32;
    localparam int LANES  = WORD_W / CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_REQ,
        WK_DATA,
        WK_FIN
    } wk_state_t;

    // One 32-bit lane, MSB first, non-reflected.
    function automatic logic [CRC_W-1:0] crc_lane_step(
        input logic [CRC_W-1:0] c,
        input logic [CRC_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction

    // A full flash word, least significant lane first.
    function automatic logic [CRC_W-1:0] crc_word_step(
        input logic [CRC_W-1:0]  c,
        input logic [WORD_W-1:0] w
    );
        logic [CRC_W-1:0] r;
        r = c;
        for (int l = 0; l < LANES; l++) begin
            r = crc_lane_step(r, w[l*CRC_W +: CRC_W]);
        end
        return r;
    endfunction
endpackage

// File: rtl/fcrc_cfg.sv
`timescale 1ns/1ps
// Configuration state: the sector bitmap and the self-clearing start and
// all-sectors flags. Assumes strobes are single-cycle pulses; everything
// is held clear while the enable is low.
module fcrc_cfg #(
    parameter int NSECT  = 4,
    parameter int SIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic [SIDX_W-1:0] sect_num,
    input  logic              add_sect,
    input  logic              clean_list,
    input  logic              all_sect_req,
    input  logic              start_req,
    input  logic              busy,
    input  logic              launch,
    output logic [NSECT-1:0]  list_q,
    output logic [NSECT-1:0]  eff_list,
    output logic              start_pend,
    output logic              all_pend
);
    // List seen by the walker at launch: all ones if the fill is armed.
    always_comb eff_list = all_pend ? {NSECT{1'b1}} : list_q;

    // Pending flags: armed by strobes, consumed at launch.
    always_ff @(posedge clk) begin
        if (!rst_n || !crc_en) begin
            start_pend <= 1'b0;
            all_pend   <= 1'b0;
        end else begin
            if (launch)
                start_pend <= 1'b0;
            else if (start_req && !busy && !start_pend)
                start_pend <= 1'b1;

            if (launch)
                all_pend <= 1'b0;
            else if (all_sect_req)
                all_pend <= 1'b1;
        end
    end

    // Sector bitmap: fill at launch, otherwise clear has priority over add.
    always_ff @(posedge clk) begin
        if (!rst_n || !crc_en) begin
            list_q <= '0;
        end else if (launch && all_pend) begin
            list_q <= {NSECT{1'b1}};
        end else if (clean_list) begin
            list_q <= '0;
        end else if (add_sect) begin
            list_q[sect_num] <= 1'b1;
        end
    end
endmodule

// File: rtl/fcrc_walker.sv
`timescale 1ns/1ps
// Address walker: issues burst requests over a range or over the sectors of
// a bitmap snapshot, and counts data beats. Assumes the sector size is a
// multiple of the largest burst and that all sectors fit in the address space.
module fcrc_walker
    import fcrc_pkg::*;
#(
    parameter int ADDR_W          = 17,
    parameter int NSECT           = 4,
    parameter int SIDX_W          = 2,
    parameter int SECT_BYTES      = 8192,
    parameter int MIN_BURST_WORDS = 4,
    parameter int SEL_W           = 2,
    parameter int LEN_W           = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              start_pend,
    input  logic              by_sect,
    input  logic [SEL_W-1:0]  burst_sel,
    input  logic [ADDR_W-1:0] range_start,
    input  logic [ADDR_W-1:0] range_end,
    input  logic [NSECT-1:0]  eff_list,
    input  logic              rd_ack,
    input  logic              rd_vld,
    output logic              launch,
    output logic              busy,
    output logic              beat,
    output logic              fin,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int SECT_SH    = $clog2(SECT_BYTES);
    localparam logic [ADDR_W-1:0] MIN_BB = ADDR_W'(MIN_BURST_WORDS * WORD_BYTES);

    // Burst size in bytes for a size code.
    function automatic logic [ADDR_W-1:0] burst_bytes(input logic [SEL_W-1:0] s);
        return MIN_BB << {s, 1'b0};
    endfunction

    // Burst size in words for a size code.
    function automatic logic [LEN_W-1:0] burst_words(input logic [SEL_W-1:0] s);
        return LEN_W'(MIN_BURST_WORDS) << {s, 1'b0};
    endfunction

    // Lowest set bit at or above 'from'; MSB of the result flags a hit.
    function automatic logic [SIDX_W:0] pick_from(
        input logic [NSECT-1:0] l,
        input int               from
    );
        logic [SIDX_W:0] r;
        r = '0;
        for (int i = NSECT - 1; i >= 0; i--) begin
            if (l[i] && i >= from) r = {1'b1, SIDX_W'(i)};
        end
        return r;
    endfunction

    wk_state_t         st;
    logic [ADDR_W-1:0] addr_q, last_q;
    logic [NSECT-1:0]  snap_q;
    logic [SIDX_W-1:0] cur_q;
    logic [LEN_W-1:0]  beat_q;
    logic [SEL_W-1:0]  sel_q;
    logic              mode_q;

    logic [ADDR_W-1:0] bb_in, bb_now, step_addr;
    logic [SIDX_W:0]   first_pick, next_pick;
    logic              last_beat, sect_wrap, range_last;

    // Status outputs and request port, all from the state register.
    always_comb begin
        launch  = (st == WK_IDLE) && start_pend && crc_en;
        busy    = (st != WK_IDLE);
        beat    = (st == WK_DATA) && rd_vld;
        fin     = (st == WK_FIN);
        rd_req  = (st == WK_REQ);
        rd_addr = addr_q;
        rd_len  = burst_words(sel_q);
    end

    // Next-address and end-of-walk decisions.
    always_comb begin
        bb_in      = burst_bytes(burst_sel);
        bb_now     = burst_bytes(sel_q);
        step_addr  = addr_q + bb_now;
        first_pick = pick_from(eff_list, 0);
        next_pick  = pick_from(snap_q, int'(cur_q) + 1);
        last_beat  = beat && (beat_q == rd_len - 1'b1);
        sect_wrap  = (step_addr[SECT_SH-1:0] == '0);
        range_last = (addr_q >= last_q);
    end

    // Walk sequencing: launch, request, beat count, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n || !crc_en) begin
            st     <= WK_IDLE;
            addr_q <= '0;
            last_q <= '0;
            snap_q <= '0;
            cur_q  <= '0;
            beat_q <= '0;
            sel_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            case (st)
                WK_IDLE: if (launch) begin
                    sel_q  <= burst_sel;
                    mode_q <= by_sect;
                    snap_q <= eff_list;
                    beat_q <= '0;
                    if (by_sect) begin
                        if (first_pick[SIDX_W]) begin
                            addr_q <= ADDR_W'(first_pick[SIDX_W-1:0]) << SECT_SH;
                            cur_q  <= first_pick[SIDX_W-1:0];
                            st     <= WK_REQ;
                        end else begin
                            st <= WK_FIN;
                        end
                    end else begin
                        addr_q <= range_start & ~(bb_in - 1'b1);
                        last_q <= range_end & ~(bb_in - 1'b1);
                        st     <= WK_REQ;
                    end
                end
                WK_REQ: if (rd_ack) begin
                    beat_q <= '0;
                    st     <= WK_DATA;
                end
                WK_DATA: if (beat) begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        if (!mode_q) begin
                            if (range_last) begin
                                st <= WK_FIN;
                            end else begin
                                addr_q <= step_addr;
                                st     <= WK_REQ;
                            end
                        end else if (!sect_wrap) begin
                            addr_q <= step_addr;
                            st     <= WK_REQ;
                        end else if (next_pick[SIDX_W]) begin
                            addr_q <= ADDR_W'(next_pick[SIDX_W-1:0]) << SECT_SH;
                            cur_q  <= next_pick[SIDX_W-1:0];
                            st     <= WK_REQ;
                        end else begin
                            st <= WK_FIN;
                        end
                    end
                end
                WK_FIN: st <= WK_IDLE;
                default: st <= WK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fcrc_engine.sv
`timescale 1ns/1ps
// Checksum accumulator and completion flag. Assumes the walker marks each
// accepted beat and the finishing cycle; absorbs one full word per beat.
module fcrc_engine
    import fcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              launch,
    input  logic              beat,
    input  logic              fin,
    input  logic              busy,
    input  logic              clean_crc,
    input  logic [WORD_W-1:0] rd_data,
    output logic [CRC_W-1:0]  crc_q,
    output logic              done_q
);
    // Seed at launch, fold each beat, flag at finish, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || !crc_en) begin
            crc_q  <= '0;
            done_q <= 1'b0;
        end else if (launch) begin
            crc_q  <= CRC_INIT;
            done_q <= 1'b0;
        end else if (beat) begin
            crc_q <= crc_word_step(crc_q, rd_data);
        end else if (fin) begin
            done_q <= 1'b1;
        end else if (clean_crc && !busy) begin
            crc_q  <= '0;
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fcrc_seq.sv
`timescale 1ns/1ps
// Top of the flash region checksum sequencer: ties configuration, walker and
// checksum engine together. Assumes an external memory answers each accepted
// burst with exactly rd_len beats of 128-bit words.
module fcrc_seq
    import fcrc_pkg::*;
#(
    parameter int ADDR_W          = 17,
    parameter int NSECT           = 4,
    parameter int SECT_BYTES      = 8192,
    parameter int MIN_BURST_WORDS = 4,
    parameter int SEL_W           = 2,
    localparam int SIDX_W = (NSECT > 1) ? $clog2(NSECT) : 1,
    localparam int LEN_W  = $clog2(MIN_BURST_WORDS) + 2 * ((1 << SEL_W) - 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              by_sect,
    input  logic [SEL_W-1:0]  burst_sel,
    input  logic [ADDR_W-1:0] range_start,
    input  logic [ADDR_W-1:0] range_end,
    input  logic [SIDX_W-1:0] sect_num,
    input  logic              add_sect,
    input  logic              clean_list,
    input  logic              all_sect_req,
    input  logic              start_req,
    input  logic              clean_crc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len,
    input  logic              rd_ack,
    input  logic              rd_vld,
    input  logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [CRC_W-1:0]  crc_out,
    output logic [NSECT-1:0]  sect_list,
    output logic              start_pend,
    output logic              all_pend
);
    logic             launch, beat, fin;
    logic [NSECT-1:0] eff_list;

    fcrc_cfg #(
        .NSECT (NSECT),
        .SIDX_W(SIDX_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .crc_en      (crc_en),
        .sect_num    (sect_num),
        .add_sect    (add_sect),
        .clean_list  (clean_list),
        .all_sect_req(all_sect_req),
        .start_req   (start_req),
        .busy        (busy),
        .launch      (launch),
        .list_q      (sect_list),
        .eff_list    (eff_list),
        .start_pend  (start_pend),
        .all_pend    (all_pend)
    );

    fcrc_walker #(
        .ADDR_W         (ADDR_W),
        .NSECT          (NSECT),
        .SIDX_W         (SIDX_W),
        .SECT_BYTES     (SECT_BYTES),
        .MIN_BURST_WORDS(MIN_BURST_WORDS),
        .SEL_W          (SEL_W),
        .LEN_W          (LEN_W)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .crc_en     (crc_en),
        .start_pend (start_pend),
        .by_sect    (by_sect),
        .burst_sel  (burst_sel),
        .range_start(range_start),
        .range_end  (range_end),
        .eff_list   (eff_list),
        .rd_ack     (rd_ack),
        .rd_vld     (rd_vld),
        .launch     (launch),
        .busy       (busy),
        .beat       (beat),
        .fin        (fin),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_len     (rd_len)
    );

    fcrc_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .crc_en   (crc_en),
        .launch   (launch),
        .beat     (beat),
        .fin      (fin),
        .busy     (busy),
        .clean_crc(clean_crc),
        .rd_data  (rd_data),
        .crc_q    (crc_out),
        .done_q   (done)
    );
endmodule

// File: rtl/fcrc_seq_chk.sv
`timescale 1ns/1ps
// Property checker for fcrc_seq, attached by bind. Observes ports only.
module fcrc_seq_chk #(
    parameter int ADDR_W          = 17,
    parameter int NSECT           = 4,
    parameter int MIN_BURST_WORDS = 4,
    parameter int LEN_W           = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              crc_en,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [LEN_W-1:0]  rd_len,
    input logic              busy,
    input logic              done,
    input logic [31:0]       crc_out,
    input logic [NSECT-1:0]  sect_list,
    input logic              start_pend
);
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[5:0] == 6'd0));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && crc_en) |=> rd_req);

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ($countones(rd_len) == 1 && rd_len >= LEN_W'(MIN_BURST_WORDS)));

    assert_start_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pend |=> !start_pend);

    assert_launch_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_en |=> (!busy && crc_out == 32'd0 && sect_list == '0 && !start_pend));
endmodule

bind fcrc_seq fcrc_seq_chk #(
    .ADDR_W         (ADDR_W),
    .NSECT          (NSECT),
    .MIN_BURST_WORDS(MIN_BURST_WORDS),
    .LEN_W          (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_en    (crc_en),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_addr   (rd_addr),
    .rd_len    (rd_len),
    .busy      (busy),
    .done      (done),
    .crc_out   (crc_out),
    .sect_list (sect_list),
    .start_pend(start_pend)
);

// File: tb/fcrc_seq_bench.sv
`timescale 1ns/1ps
module fcrc_seq_bench;
    logic         clk = 1'b0;
    logic         rst_n, crc_en, by_sect;
    logic [1:0]   burst_sel, sect_num;
    logic [16:0]  range_start, range_end;
    logic         add_sect, clean_list, all_sect_req, start_req, clean_crc;
    logic         rd_req, rd_ack, rd_vld;
    logic [16:0]  rd_addr;
    logic [8:0]   rd_len;
    logic [127:0] rd_data;
    logic         busy, done, start_pend, all_pend;
    logic [31:0]  crc_out;
    logic [3:0]   sect_list;

    always #5 clk = ~clk;

    fcrc_seq u_fcrc_seq (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .by_sect(by_sect),
        .burst_sel(burst_sel), .range_start(range_start), .range_end(range_end),
        .sect_num(sect_num), .add_sect(add_sect), .clean_list(clean_list),
        .all_sect_req(all_sect_req), .start_req(start_req), .clean_crc(clean_crc),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_ack(rd_ack),
        .rd_vld(rd_vld), .rd_data(rd_data), .busy(busy), .done(done),
        .crc_out(crc_out), .sect_list(sect_list), .start_pend(start_pend),
        .all_pend(all_pend)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit mon_free = 1'b0;
    logic [16:0] exp_addr_q[$];
    logic [8:0]  exp_len_q[$];
    logic [31:0] exp_crc_q[$];

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [127:0] mem_word(input logic [16:0] a);
        logic [127:0] w;
        for (int l = 0; l < 4; l++)
            w[32*l +: 32] = ({15'd0, a} * 32'h9E37_79B1) ^ (32'h0101_0101 * l) ^ 32'h5A5A_0000;
        return w;
    endfunction

    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [127:0] w);
        logic [31:0] r, d;
        logic top;
        r = c;
        for (int l = 0; l < 4; l++) begin
            d = w[32*l +: 32];
            for (int b = 0; b < 32; b++) begin
                top = r[31] ^ d[31-b];
                r = {r[30:0], 1'b0};
                if (top) r = r ^ 32'h04C1_1DB7;
            end
        end
        return r;
    endfunction

    task automatic push_burst(input logic [16:0] a, input int words, inout logic [31:0] c);
        exp_addr_q.push_back(a);
        exp_len_q.push_back(9'(words));
        for (int i = 0; i < words; i++) c = ref_fold(c, mem_word(a + 17'(16 * i)));
    endtask

    task automatic do_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        chk(start_pend == 1'b1 && busy == 1'b0, "R9 start armed, not yet busy", {start_pend, busy}, 32'h2);
        @(negedge clk);
        chk(start_pend == 1'b0 && busy == 1'b1, "R9 start consumed at launch", {start_pend, busy}, 32'h1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_range(input logic [16:0] s, input logic [16:0] e, input logic [1:0] sel);
        logic [16:0] bb, a, last;
        logic [31:0] c;
        int words;
        bb = 17'd64 << (2 * sel);
        words = 4 << (2 * sel);
        a = s & ~(bb - 17'd1);
        last = e & ~(bb - 17'd1);
        c = 32'hFFFF_FFFF;
        forever begin
            push_burst(a, words, c);
            if (a >= last) break;
            a = a + bb;
        end
        exp_crc_q.push_back(c);
        by_sect = 1'b0; burst_sel = sel; range_start = s; range_end = e;
        do_start();
        wait_done();
    endtask

    task automatic run_sect(input logic [3:0] lst, input logic [1:0] sel);
        logic [16:0] bb;
        logic [31:0] c;
        int words;
        bb = 17'd64 << (2 * sel);
        words = 4 << (2 * sel);
        c = 32'hFFFF_FFFF;
        for (int s = 0; s < 4; s++)
            if (lst[s])
                for (int off = 0; off < 8192; off += int'(bb))
                    push_burst(17'(s * 8192 + off), words, c);
        exp_crc_q.push_back(c);
        by_sect = 1'b1; burst_sel = sel;
        do_start();
        wait_done();
    endtask

    task automatic pulse_add(input logic [1:0] n);
        @(negedge clk); sect_num = n; add_sect = 1'b1;
        @(negedge clk); add_sect = 1'b0;
    endtask

    // Monitor: memory model that checks each burst request against the queue.
    initial begin
        logic [16:0] a, ea;
        logic [8:0]  l, el;
        rd_ack = 1'b0; rd_vld = 1'b0; rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_req === 1'b1) begin
                a = rd_addr; l = rd_len;
                if (!mon_free) begin
                    if (exp_addr_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected burst request", {15'd0, a}, 32'd0);
                    end else begin
                        ea = exp_addr_q.pop_front();
                        el = exp_len_q.pop_front();
                        chk(a == ea, "R2 R6 burst address", {15'd0, a}, {15'd0, ea});
                        chk(l == el, "R3 burst length", {23'd0, l}, {23'd0, el});
                    end
                end
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
                for (int i = 0; i < int'(l); i++) begin
                    rd_vld = 1'b1;
                    rd_data = mem_word(a + 17'(16 * i));
                    @(negedge clk);
                end
                rd_vld = 1'b0;
            end
        end
    end

    // Monitor: checksum result compared on each rising completion flag.
    initial begin
        logic prev;
        logic [31:0] ec;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !prev) begin
                chk(busy == 1'b0, "R10 done with busy low", {31'd0, busy}, 32'd0);
                if (exp_crc_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected completion", crc_out, 32'd0);
                end else begin
                    ec = exp_crc_q.pop_front();
                    chk(crc_out == ec, "R4 checksum result", crc_out, ec);
                end
            end
            prev = done;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        rst_n = 1'b0; crc_en = 1'b0; by_sect = 1'b0; burst_sel = 2'd0; sect_num = 2'd0;
        range_start = '0; range_end = '0; add_sect = 1'b0; clean_list = 1'b0;
        all_sect_req = 1'b0; start_req = 1'b0; clean_crc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_req, "R1 busy/done/req idle", {busy, done, rd_req}, 32'd0);
        chk(crc_out == 32'd0, "R1 result zero", crc_out, 32'd0);
        chk(sect_list == 4'd0 && !start_pend && !all_pend, "R1 list and flags clear",
            {sect_list, start_pend, all_pend}, 32'd0);

        crc_en = 1'b1;
        @(negedge clk);
        // R2 R3 range runs with unaligned bounds and various burst sizes
        run_range(17'h00047, 17'h0013F, 2'd0);
        chk(done && crc_out != 32'd0, "R10 result held after run", {31'd0, done}, 32'd1);
        run_range(17'h01234, 17'h01500, 2'd1);
        run_range(17'h00800, 17'h00400, 2'd2);

        // R5 list build
        pulse_add(2'd2);
        pulse_add(2'd0);
        chk(sect_list == 4'b0101, "R5 list after two adds", {28'd0, sect_list}, 32'h5);
        // R6 ascending sparse list, large bursts
        run_sect(4'b0101, 2'd3);
        @(negedge clk); clean_list = 1'b1;
        @(negedge clk); clean_list = 1'b0;
        chk(sect_list == 4'b0000, "R5 clean empties list", {28'd0, sect_list}, 32'd0);
        pulse_add(2'd1);
        run_sect(4'b0010, 2'd0);

        // R5 clean wins over simultaneous add
        @(negedge clk); clean_list = 1'b1; add_sect = 1'b1; sect_num = 2'd3;
        @(negedge clk); clean_list = 1'b0; add_sect = 1'b0;
        chk(sect_list == 4'b0000, "R5 clean beats add", {28'd0, sect_list}, 32'd0);
        // R7 empty list
        run_sect(4'b0000, 2'd1);
        chk(crc_out == 32'hFFFF_FFFF, "R7 empty list result", crc_out, 32'hFFFF_FFFF);

        // R8 all sectors
        @(negedge clk); all_sect_req = 1'b1;
        @(negedge clk); all_sect_req = 1'b0;
        chk(all_pend == 1'b1, "R8 fill armed", {31'd0, all_pend}, 32'd1);
        run_sect(4'b1111, 2'd3);
        chk(all_pend == 1'b0 && sect_list == 4'b1111, "R8 fill applied and self-cleared",
            {sect_list, all_pend}, {4'b1111, 1'b0});

        // R11 clear result while idle
        @(negedge clk); clean_crc = 1'b1;
        @(negedge clk); clean_crc = 1'b0;
        chk(crc_out == 32'd0 && !done, "R11 result cleared", crc_out, 32'd0);

        // R12 abort by disabling, then strobes while disabled
        mon_free = 1'b1;
        by_sect = 1'b0; burst_sel = 2'd0; range_start = 17'h0; range_end = 17'h07FC0;
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R12 run in progress before abort", {31'd0, busy}, 32'd1);
        crc_en = 1'b0;
        @(negedge clk);
        chk(!busy && crc_out == 32'd0 && sect_list == 4'd0 && !done, "R12 disable clears state",
            {busy, done, sect_list}, 32'd0);
        sect_num = 2'd1; add_sect = 1'b1; start_req = 1'b1; all_sect_req = 1'b1;
        @(negedge clk);
        add_sect = 1'b0; start_req = 1'b0; all_sect_req = 1'b0;
        @(negedge clk);
        chk(sect_list == 4'd0 && !start_pend && !all_pend && !busy, "R12 strobes ignored while disabled",
            {sect_list, start_pend, all_pend, busy}, 32'd0);
        repeat (20) @(negedge clk);
        mon_free = 1'b0;
        crc_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req, "R12 no run after re-enable", {busy, rd_req}, 32'd0);

        chk(exp_addr_q.size() == 0, "R2 all expected bursts issued", exp_addr_q.size(), 32'd0);
        chk(exp_crc_q.size() == 0, "R10 all runs completed", exp_crc_q.size(), 32'd0);
        report();
    end
endmodule